// File: doc/BRIEF.md
# Chainable Three-Wire Configuration Receiver

This block takes a slow three-wire serial stream (a serial clock, a data line and a latch strobe) and turns it into parallel command words for a configuration controller. All three wires are oversampled by the fast system clock. Two-flop synchronizers bring them into the system clock domain, and their edges are detected there. Each rising serial clock edge moves one data bit into a shift register. A rising latch edge copies the register into the command output and raises a word-valid flag for a single system cycle.

A pass-through output repeats the incoming data fifteen and a half serial clocks later, and it only changes on falling serial clock edges. Several receivers can therefore share one clock line and one latch line, with each output wired into the next receiver's data input. The host sends sixteen bits for every receiver in the chain, then gives one latch pulse. Every receiver then captures its own word at the same moment. The farthest receiver in the chain gets the first word that was sent.

Top module: `cfg_serial_port`

## Requirements
- R1: One data bit is shifted in on every rising serial clock edge, whether the latch strobe is high or low. Bits shifted while the latch is held high are captured by the next rising latch edge.
- R2: Bits arrive least significant first. After sixteen rising serial clock edges, the first bit received is at bit 0 of the captured word and the last bit received is at bit 15.
- R3: `cmdWord` changes only in response to a rising latch edge. A falling latch edge leaves `cmdWord` unchanged and produces no `wordValid` pulse.
- R4: `sdoOut` repeats `sdiIn` with a delay. The bit sampled on rising serial clock edge k appears on the falling edge that follows rising edge k+15. Before fifteen bits have been received since reset, the value shown is 0.
- R5: `sdoOut` changes only after a falling serial clock edge. It holds steady through the whole high phase of the serial clock.
- R6: When two receivers are chained (the first receiver's `sdoOut` feeds the second receiver's `sdiIn`) and 32 bits are sent followed by one latch pulse, the second receiver captures the first word sent and the first receiver captures the second word.
- R7: `wordValid` is high for exactly one system clock cycle for each rising latch edge, even when the latch stays high for many cycles.
- R8: While `rstN` is low, and directly after reset, `cmdWord` is 0, `sdoOut` is 0 and `wordValid` is 0. The shift register is also cleared.
- R9: Operation is correct when each serial clock phase, and the time from the last falling clock edge to the latch edge, lasts at least four system clock cycles (a serial period of eight system cycles).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rstN | input | 1 | Asynchronous reset, active low |
| sclkIn | input | 1 | Serial clock, asynchronous to clk |
| sdiIn | input | 1 | Serial data, sampled on rising sclkIn |
| latchIn | input | 1 | Latch strobe; a rising edge captures the word |
| cmdWord | output | WORD_W | Most recently captured command word |
| wordValid | output | 1 | One-cycle pulse when cmdWord is updated |
| sdoOut | output | 1 | Delayed copy of the data, for chaining |

## Verification
The checker watches every cycle for four things: `wordValid` never lasts two cycles in a row; `cmdWord` never changes without `wordValid`; `wordValid` only follows a detected latch rising edge; and `sdoOut` only moves in the cycle after a detected falling edge of the serial clock. Other properties can only be shown by the bench scenarios: the bit order inside the word, the exact fifteen-and-a-half-clock delay on the pass-through, capture of bits shifted in while the latch was high, correct operation at the minimum oversampling ratio, and the word split across two chained receivers.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

  // Strobes from the edge-detecting control to the datapath
  typedef struct packed {
    logic shiftEn;    // rising serial clock seen
    logic sdoEn;      // falling serial clock seen
    logic captureEn;  // rising latch seen
  } cfg_strobe_t;

  localparam int unsigned CFG_DEF_WORD_W = 16;
  localparam int unsigned CFG_DEF_SYNC   = 2;

endpackage

// File: rtl/cfg_sync_bit.sv
module cfg_sync_bit #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic qOut
);

  logic [STAGES-1:0] chainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chainQ <= '0;
    else       chainQ <= {chainQ[STAGES-2:0], dIn};
  end

  assign qOut = chainQ[STAGES-1];

endmodule

// File: rtl/cfg_serial_ctrl.sv
module cfg_serial_ctrl
  import cfg_serial_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = CFG_DEF_SYNC
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkIn,
  input  logic        sdiIn,
  input  logic        latchIn,
  output cfg_strobe_t strobes,
  output logic        sdiBit
);

  localparam int unsigned NUM_WIRES = 3;
  localparam int unsigned IDX_SCLK  = 0;
  localparam int unsigned IDX_SDI   = 1;
  localparam int unsigned IDX_LATCH = 2;

  logic [NUM_WIRES-1:0] rawWires;
  logic [NUM_WIRES-1:0] syncWires;
  logic                 sclkPrev;
  logic                 latchPrev;

  assign rawWires[IDX_SCLK]  = sclkIn;
  assign rawWires[IDX_SDI]   = sdiIn;
  assign rawWires[IDX_LATCH] = latchIn;

  // Same depth on every wire keeps data aligned with its clock edge
  for (genvar w = 0; w < NUM_WIRES; w++) begin : g_sync
    cfg_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .dIn  (rawWires[w]),
      .qOut (syncWires[w])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      sclkPrev  <= syncWires[IDX_SCLK];
      latchPrev <= syncWires[IDX_LATCH];
    end
  end

  always_comb begin
    strobes.shiftEn   = syncWires[IDX_SCLK] & ~sclkPrev;
    strobes.sdoEn     = ~syncWires[IDX_SCLK] & sclkPrev;
    strobes.captureEn = syncWires[IDX_LATCH] & ~latchPrev;
  end

  assign sdiBit = syncWires[IDX_SDI];

endmodule

// File: rtl/cfg_serial_dp.sv
module cfg_serial_dp
  import cfg_serial_pkg::*;
#(
  parameter int unsigned WORD_W = CFG_DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       strobes,
  input  logic              sdiBit,
  output logic [WORD_W-1:0] cmdWord,
  output logic              wordValid,
  output logic              sdoOut
);

  logic [WORD_W-1:0] shiftReg;

  // New bits enter at the top, so the oldest bit reaches index 0
  // after WORD_W-1 further shifts and leaves on the next falling edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      cmdWord   <= '0;
      wordValid <= 1'b0;
      sdoOut    <= 1'b0;
    end else begin
      wordValid <= strobes.captureEn;
      if (strobes.shiftEn)   shiftReg <= {sdiBit, shiftReg[WORD_W-1:1]};
      if (strobes.sdoEn)     sdoOut   <= shiftReg[0];
      if (strobes.captureEn) cmdWord  <= shiftReg;
    end
  end

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_serial_pkg::*;
#(
  parameter int unsigned WORD_W      = CFG_DEF_WORD_W,
  parameter int unsigned SYNC_STAGES = CFG_DEF_SYNC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              sdiIn,
  input  logic              latchIn,
  output logic [WORD_W-1:0] cmdWord,
  output logic              wordValid,
  output logic              sdoOut
);

  cfg_strobe_t strobes;
  logic        sdiBit;

  cfg_serial_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclkIn  (sclkIn),
    .sdiIn   (sdiIn),
    .latchIn (latchIn),
    .strobes (strobes),
    .sdiBit  (sdiBit)
  );

  cfg_serial_dp #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sdiBit    (sdiBit),
    .cmdWord   (cmdWord),
    .wordValid (wordValid),
    .sdoOut    (sdoOut)
  );

endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] cmdWord,
  input logic              wordValid,
  input logic              sdoOut,
  input logic              sdoEn,
  input logic              captureEn
);

  AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid); // R7

  AST_WORD_CHANGES_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWord != $past(cmdWord)) |-> wordValid); // R3

  AST_VALID_FROM_LATCH_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(captureEn)); // R3

  AST_SDO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOut != $past(sdoOut)) |-> $past(sdoEn)); // R5

endmodule

bind cfg_serial_port cfg_serial_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdWord   (cmdWord),
  .wordValid (wordValid),
  .sdoOut    (sdoOut),
  .sdoEn     (strobes.sdoEn),
  .captureEn (strobes.captureEn)
);

// File: tb/cfg_serial_port_bench.sv
module cfg_serial_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sclkIn = 1'b0;
  logic         sdiIn = 1'b0;
  logic         latchIn = 1'b0;
  logic [W-1:0] cmdWord, cmdWordB;
  logic         wordValid, wordValidB;
  logic         sdoOut, sdoOutB;

  int checks = 0;
  int errors = 0;
  int half = 6;
  bit hist[$];
  logic expSdo = 1'b0;
  logic [W-1:0] expQ[$];
  string tagQ[$];
  logic prevValid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_port u_cfg_serial_port (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdiIn(sdiIn), .latchIn(latchIn),
    .cmdWord(cmdWord), .wordValid(wordValid), .sdoOut(sdoOut)
  );

  // Second receiver downstream in the chain (R6)
  cfg_serial_port u_chain_b (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdiIn(sdoOut), .latchIn(latchIn),
    .cmdWord(cmdWordB), .wordValid(wordValidB), .sdoOut(sdoOutB)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: pops expected words as the design announces them
  always @(negedge clk) begin
    if (!rstN) prevValid <= 1'b0;
    else begin
      if (wordValid) begin
        check(!prevValid, "R7 valid wider than one cycle", {15'd0, prevValid}, '0);
        if (expQ.size() == 0) check(1'b0, "R3 unexpected wordValid", cmdWord, '0);
        else begin
          logic [W-1:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(cmdWord == e, t, cmdWord, e);
        end
      end
      prevValid <= wordValid;
    end
  end

  task automatic sendBit(input bit b);
    int m;
    @(negedge clk) sdiIn = b;
    repeat (half - 1) @(negedge clk);
    check(sdoOut == expSdo, "R4 pass-through value", {15'd0, sdoOut}, {15'd0, expSdo});
    @(negedge clk) sclkIn = 1'b1;
    hist.push_back(b);
    repeat (half - 1) @(negedge clk);
    check(sdoOut == expSdo, "R5 stable during high phase", {15'd0, sdoOut}, {15'd0, expSdo});
    @(negedge clk) sclkIn = 1'b0;
    m = hist.size() - 1;
    expSdo = (m >= 15) ? hist[m-15] : 1'b0;
  endtask

  task automatic sendWord(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) sendBit(w[i]);
  endtask

  task automatic pulseLatch(input logic [W-1:0] exp, input int hold, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    repeat (half) @(negedge clk);
    latchIn = 1'b1;
    repeat (hold) @(negedge clk);
    latchIn = 1'b0;
    repeat (8) @(negedge clk);
    check(cmdWord == exp, "R3 falling latch keeps word", cmdWord, exp);
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(cmdWord == '0, "R8 cmdWord in reset", cmdWord, '0);
    check(sdoOut == 1'b0, "R8 sdoOut in reset", {15'd0, sdoOut}, '0);
    check(wordValid == 1'b0, "R8 wordValid in reset", {15'd0, wordValid}, '0);
    hist.delete();
    expSdo = 1'b0;
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();

    // R2: mixed pattern, bit order
    sendWord(16'hA5C3);
    pulseLatch(16'hA5C3, 2, "R2 mixed word order");

    // R2: only the first bit sent is set
    sendWord(16'h0001);
    pulseLatch(16'h0001, 2, "R2 first bit lands at bit 0");

    // R7: latch held high for a long time
    sendWord(16'h8000);
    pulseLatch(16'h8000, 25, "R7 long latch single capture");

    // R1: shifting while latch high; falling edge must not capture
    expQ.push_back(16'h8000);
    tagQ.push_back("R1 rise before shifting");
    repeat (half) @(negedge clk);
    latchIn = 1'b1;
    repeat (6) @(negedge clk);
    sendWord(16'h3C96);
    latchIn = 1'b0;
    repeat (8) @(negedge clk);
    check(cmdWord == 16'h8000, "R3 fall after shifting ignored", cmdWord, 16'h8000);
    pulseLatch(16'h3C96, 2, "R1 bits shifted under high latch");

    // R9: minimum oversampling ratio
    half = 4;
    sendWord(16'hF00F);
    pulseLatch(16'hF00F, 2, "R9 eight system cycles per bit");
    half = 6;

    // R6: two chained receivers
    sendWord(16'h1234);
    sendWord(16'hBEEF);
    pulseLatch(16'hBEEF, 2, "R6 near receiver gets second word");
    check(cmdWordB == 16'h1234, "R6 far receiver gets first word", cmdWordB, 16'h1234);

    // R8: reset in the middle of operation
    doReset();
    sendWord(16'h5A5A);
    pulseLatch(16'h5A5A, 3, "R8 operation after reset");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R3 every latch edge produced a word",
          16'(expQ.size()), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule